// File: doc/BRIEF.md
# Shared-Memory Hardware Queue Engine

This block keeps several circular FIFO queues inside one word-addressed memory. Each queue is described by a single 32-bit control word that software writes through a plain register port. The word holds the queue's two word pointers, the 16-word-aligned location of its buffer in the shared memory, and log2 codes for the entry width, the buffer length and two watermark thresholds.

One access port serves all queues. A write command pushes one entry of 1, 2 or 4 words into the chosen queue. A read command pops one entry and returns it on the following cycle. For every queue the block derives the Empty, Nearly-Empty, Nearly-Full and Full flags from the pointer occupancy and the watermark codes. It also keeps sticky underflow and overflow bits, which software clears by writing 1 to them.

Top module: `hwq_engine`

## Requirements
- R1: After reset every control word reads 0. Every queue shows Empty and Nearly-Empty, no queue shows Full or Nearly-Full, and all sticky bits are 0.
- R2: A control-word write stores the whole word, and it reads back on `cfg_rdata` when `cfg_qid` selects that queue. The write also makes equal pointers mean empty. Field layout: bits 6:0 are the write pointer, 13:7 the read pointer, 21:14 the base in 16-word units, 23:22 the entry code, 25:24 the buffer code, 28:26 the nearly-empty code and 31:29 the nearly-full code.
- R3: A push stores entry word k at memory word base*16 + ((write pointer + k) mod buffer words). A pop returns the oldest entry one cycle later, with `acc_rvalid` high and word k in `acc_rdata` bits 32k+31:32k. Words beyond the entry width read as 0.
- R4: Each pointer advances by the entry width and wraps modulo the buffer length. Entry codes 0, 1 and 2 give 1, 2 and 4 words, and code 3 also gives 4 words. Buffer codes 0 to 3 give 16, 32, 64 and 128 words.
- R5: Full is high when the occupancy in entries equals the buffer words divided by the entry words. Empty is high at zero occupancy. Equal pointers after a complete wrap mean Full.
- R6: Nearly-Empty is high when the occupancy is at or below the nearly-empty threshold. A threshold code of 0 means 0 entries, and a code n greater than 0 means 2^(n-1) entries.
- R7: Nearly-Full is high when the free entries are at or below the nearly-full threshold, which is coded in the same way as in R6.
- R8: A pop from an empty queue returns all zeros with `acc_rvalid` high, leaves the pointers unchanged and sets that queue's sticky underflow bit.
- R9: A push to a full queue stores nothing, leaves the pointers unchanged and sets that queue's sticky overflow bit.
- R10: A `stat_clr` write with mask bit 0 clears underflow and with mask bit 1 clears overflow for `stat_clr_qid`. When a new event and a clear arrive in the same cycle, the event wins.
- R11: Queues do not disturb one another. An access to a queue whose control word is being written in the same cycle is dropped, and it produces no `acc_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control-word write strobe |
| cfg_qid | input | QW | Queue selected for control-word write and readback |
| cfg_wdata | input | 32 | Control word to store |
| cfg_rdata | output | 32 | Control word of `cfg_qid` |
| acc_valid | input | 1 | Access command valid |
| acc_write | input | 1 | 1 = push, 0 = pop |
| acc_qid | input | QW | Queue addressed by the access |
| acc_wdata | input | 4*DW | Entry to push, word k at bits 32k+31:32k |
| acc_rvalid | output | 1 | Pop result valid |
| acc_rdata | output | 4*DW | Popped entry |
| stat_clr | input | 1 | Sticky clear strobe |
| stat_clr_qid | input | QW | Queue whose sticky bits are cleared |
| stat_clr_mask | input | 2 | Bit 0 clears underflow, bit 1 clears overflow |
| q_empty | output | NQ | Empty flag per queue |
| q_nempty | output | NQ | Nearly-Empty flag per queue |
| q_nfull | output | NQ | Nearly-Full flag per queue |
| q_full | output | NQ | Full flag per queue |
| q_underflow | output | NQ | Sticky underflow per queue |
| q_overflow | output | NQ | Sticky overflow per queue |

## Verification
The hardest state to reach is a full queue whose read and write pointers are equal somewhere other than zero. Only the hidden wrap bits tell that state apart from empty. The stimulus fills a 4-word-entry queue to capacity, drains part of it and refills it, so both pointers wrap at different times and meet at word 12. A second queue starts with both pointers seeded near the buffer end through a control-word write, so its very first push wraps the write pointer. It then checks that the data lands at the top of its buffer.

// File: rtl/hwq_engine.sv
module hwq_engine #(
  parameter int NQ = 4,
  parameter int MEM_WORDS = 256,
  parameter int DW = 32,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int AW = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [QW-1:0]     cfg_qid,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [QW-1:0]     acc_qid,
  input  logic [4*DW-1:0]   acc_wdata,
  output logic              acc_rvalid,
  output logic [4*DW-1:0]   acc_rdata,
  input  logic              stat_clr,
  input  logic [QW-1:0]     stat_clr_qid,
  input  logic [1:0]        stat_clr_mask,
  output logic [NQ-1:0]     q_empty,
  output logic [NQ-1:0]     q_nempty,
  output logic [NQ-1:0]     q_nfull,
  output logic [NQ-1:0]     q_full,
  output logic [NQ-1:0]     q_underflow,
  output logic [NQ-1:0]     q_overflow
);

  logic [31:0]   cfg_q [NQ];
  logic [NQ-1:0] wrap_w, wrap_r;
  logic [DW-1:0] mem [MEM_WORDS];

  function automatic logic [7:0] wm_thr(input logic [2:0] code);
    return (code == 3'd0) ? 8'd0 : (8'd1 << (code - 3'd1));
  endfunction

  function automatic logic [AW-1:0] waddr(input logic [7:0] base, input logic [6:0] ptr,
                                          input int k, input logic [6:0] msk);
    logic [12:0] a;
    a = {1'b0, base, 4'b0} + {6'b0, (ptr + 7'(k)) & msk};
    return a[AW-1:0];
  endfunction

  assign cfg_rdata = cfg_q[cfg_qid];

  for (genvar g = 0; g < NQ; g++) begin : g_stat
    logic [31:0] c;
    logic [7:0]  bw, occw, occ, cap;
    logic [6:0]  msk, dif;
    logic [1:0]  sh;
    assign c    = cfg_q[g];
    assign bw   = 8'd16 << c[25:24];
    assign msk  = 7'(bw - 8'd1);
    assign sh   = c[23] ? 2'd2 : {1'b0, c[22]};
    assign dif  = (c[6:0] - c[13:7]) & msk;
    assign occw = (dif == 7'd0 && wrap_w[g] != wrap_r[g]) ? bw : {1'b0, dif};
    assign occ  = occw >> sh;
    assign cap  = bw >> sh;
    assign q_empty[g]  = (occ == 8'd0);
    assign q_full[g]   = (occ == cap);
    assign q_nempty[g] = (occ <= wm_thr(c[28:26]));
    assign q_nfull[g]  = ((cap - occ) <= wm_thr(c[31:29]));
  end

  logic [31:0]   sc;
  logic [7:0]    sbw, wsum, rsum;
  logic [6:0]    smsk, swp, srp, nwp, nrp;
  logic [2:0]    esz;
  logic          blocked, rd_req, wr_req, do_push, do_pop, wwrap, rwrap;
  logic [4*DW-1:0] rword;

  assign sc      = cfg_q[acc_qid];
  assign sbw     = 8'd16 << sc[25:24];
  assign smsk    = 7'(sbw - 8'd1);
  assign esz     = sc[23] ? 3'd4 : (sc[22] ? 3'd2 : 3'd1);
  assign swp     = sc[6:0] & smsk;
  assign srp     = sc[13:7] & smsk;
  assign blocked = cfg_we && (cfg_qid == acc_qid);
  assign rd_req  = acc_valid && !acc_write && !blocked;
  assign wr_req  = acc_valid && acc_write && !blocked;
  assign do_push = wr_req && !q_full[acc_qid];
  assign do_pop  = rd_req && !q_empty[acc_qid];
  assign wsum    = {1'b0, swp} + {5'b0, esz};
  assign rsum    = {1'b0, srp} + {5'b0, esz};
  assign nwp     = wsum[6:0] & smsk;
  assign nrp     = rsum[6:0] & smsk;
  assign wwrap   = wsum > {1'b0, smsk};
  assign rwrap   = rsum > {1'b0, smsk};

  always_comb begin
    for (int k = 0; k < 4; k++)
      rword[k*DW +: DW] = (3'(k) < esz) ? mem[waddr(sc[21:14], srp, k, smsk)] : '0;
  end

  always_ff @(posedge clk) begin
    if (do_push)
      for (int k = 0; k < 4; k++)
        if (3'(k) < esz)
          mem[waddr(sc[21:14], swp, k, smsk)] <= acc_wdata[k*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NQ; i++) cfg_q[i] <= '0;
      wrap_w      <= '0;
      wrap_r      <= '0;
      q_underflow <= '0;
      q_overflow  <= '0;
      acc_rvalid  <= 1'b0;
      acc_rdata   <= '0;
    end else begin
      acc_rvalid <= rd_req;
      acc_rdata  <= do_pop ? rword : '0;
      for (int i = 0; i < NQ; i++) begin
        if (cfg_we && cfg_qid == QW'(i)) begin
          cfg_q[i]  <= cfg_wdata;
          wrap_w[i] <= 1'b0;
          wrap_r[i] <= 1'b0;
        end else if (acc_qid == QW'(i)) begin
          if (do_push) begin
            cfg_q[i][6:0] <= nwp;
            if (wwrap) wrap_w[i] <= ~wrap_w[i];
          end
          if (do_pop) begin
            cfg_q[i][13:7] <= nrp;
            if (rwrap) wrap_r[i] <= ~wrap_r[i];
          end
        end
        q_underflow[i] <= (q_underflow[i] && !(stat_clr && stat_clr_qid == QW'(i) && stat_clr_mask[0]))
                        || (rd_req && q_empty[acc_qid] && acc_qid == QW'(i));
        q_overflow[i]  <= (q_overflow[i] && !(stat_clr && stat_clr_qid == QW'(i) && stat_clr_mask[1]))
                        || (wr_req && q_full[acc_qid] && acc_qid == QW'(i));
      end
    end
  end

endmodule

// File: rtl/hwq_engine_chk.sv
module hwq_engine_chk #(
  parameter int NQ = 4,
  parameter int DW = 32,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic [QW-1:0]   cfg_qid,
  input logic            acc_valid,
  input logic            acc_write,
  input logic [QW-1:0]   acc_qid,
  input logic            acc_rvalid,
  input logic [4*DW-1:0] acc_rdata,
  input logic            stat_clr,
  input logic [QW-1:0]   stat_clr_qid,
  input logic [1:0]      stat_clr_mask,
  input logic [NQ-1:0]   q_empty,
  input logic [NQ-1:0]   q_nempty,
  input logic [NQ-1:0]   q_nfull,
  input logic [NQ-1:0]   q_full,
  input logic [NQ-1:0]   q_underflow,
  input logic [NQ-1:0]   q_overflow
);

  assert_pop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && q_empty[acc_qid] && !(cfg_we && cfg_qid == acc_qid))
    |=> (acc_rvalid && acc_rdata == '0 && q_underflow[$past(acc_qid)]));

  assert_push_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && q_full[acc_qid] && !(cfg_we && cfg_qid == acc_qid))
    |=> q_overflow[$past(acc_qid)]);

  assert_rvalid_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rvalid |-> $past(acc_valid && !acc_write));

  for (genvar i = 0; i < NQ; i++) begin : g_q
    assert_sticky_uf_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (q_underflow[i] && !(stat_clr && stat_clr_qid == QW'(i) && stat_clr_mask[0])) |=> q_underflow[i]);
    assert_sticky_of_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (q_overflow[i] && !(stat_clr && stat_clr_qid == QW'(i) && stat_clr_mask[1])) |=> q_overflow[i]);
    assert_empty_ne_R6: assert property (@(posedge clk) disable iff (!rst_n)
      q_empty[i] |-> q_nempty[i]);
    assert_full_nf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      q_full[i] |-> q_nfull[i]);
  end

endmodule

bind hwq_engine hwq_engine_chk #(.NQ(NQ), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_qid(cfg_qid),
  .acc_valid(acc_valid), .acc_write(acc_write), .acc_qid(acc_qid),
  .acc_rvalid(acc_rvalid), .acc_rdata(acc_rdata),
  .stat_clr(stat_clr), .stat_clr_qid(stat_clr_qid), .stat_clr_mask(stat_clr_mask),
  .q_empty(q_empty), .q_nempty(q_nempty), .q_nfull(q_nfull), .q_full(q_full),
  .q_underflow(q_underflow), .q_overflow(q_overflow));

// File: tb/hwq_engine_bench.sv
module hwq_engine_bench;
  localparam int NQ = 4;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, acc_valid = 0, acc_write = 0, stat_clr = 0;
  logic [1:0] cfg_qid = 0, acc_qid = 0, stat_clr_qid = 0, stat_clr_mask = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic [127:0] acc_wdata = 0, acc_rdata;
  logic acc_rvalid;
  logic [NQ-1:0] q_empty, q_nempty, q_nfull, q_full, q_underflow, q_overflow;

  int total = 0, bad = 0;
  logic [127:0] sbq[$];
  logic [31:0] w;

  always #4 clk = ~clk;

  hwq_engine #(.NQ(NQ), .MEM_WORDS(256), .DW(DW)) u_hwq_engine (.*);

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int wp, int rp, int base, int es, int bs, int ne, int nf);
    return {3'(nf), 3'(ne), 2'(bs), 2'(es), 8'(base), 7'(rp), 7'(wp)};
  endfunction

  function automatic logic [127:0] ent(int b);
    return {32'(b + 3), 32'(b + 2), 32'(b + 1), 32'(b)};
  endfunction

  task automatic cfgw(int q, logic [31:0] d);
    cfg_we = 1; cfg_qid = 2'(q); cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic push(int q, logic [127:0] d);
    acc_valid = 1; acc_write = 1; acc_qid = 2'(q); acc_wdata = d;
    @(negedge clk); acc_valid = 0;
  endtask

  task automatic pop(int q, logic [127:0] exp);
    sbq.push_back(exp);
    acc_valid = 1; acc_write = 0; acc_qid = 2'(q);
    @(negedge clk); acc_valid = 0;
  endtask

  task automatic rdcfg(int q, output logic [31:0] d);
    cfg_qid = 2'(q); #1; d = cfg_rdata;
  endtask

  task automatic flags(int q, bit e, bit ne, bit nf, bit f, string tag);
    chk(tag, {q_empty[q], q_nempty[q], q_nfull[q], q_full[q]}, {e, ne, nf, f});
  endtask

  always @(negedge clk) begin
    if (rst_n && acc_rvalid) begin
      if (sbq.size() == 0) begin
        total++; bad++;
        $display("FAIL R3 unexpected result act=%0h exp=none", acc_rdata);
      end else begin
        logic [127:0] e;
        e = sbq.pop_front();
        chk("R3 popped entry", acc_rdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 empty", 128'(q_empty), 128'hF);
    chk("R1 nempty", 128'(q_nempty), 128'hF);
    chk("R1 full/nfull", 128'({q_full, q_nfull}), 128'h0);
    chk("R1 sticky", 128'({q_underflow, q_overflow}), 128'h0);
    for (int q = 0; q < NQ; q++) begin rdcfg(q, w); chk("R1 cfg zero", 128'(w), 128'h0); end

    // queue 0: 1-word entries, 16 words, NE=4 entries, NF=2 entries
    cfgw(0, mk(0, 0, 0, 0, 0, 3, 2));
    rdcfg(0, w); chk("R2 readback", 128'(w), 128'(mk(0, 0, 0, 0, 0, 3, 2)));
    for (int j = 0; j < 16; j++) begin
      push(0, {96'hDEAD_0000_BEEF_0000_CAFE_0000, 32'(100 + j)});
      flags(0, 0, (j + 1) <= 4, (16 - (j + 1)) <= 2, (j + 1) == 16, "R5 R6 R7 q0 fill");
    end
    rdcfg(0, w); chk("R4 q0 wp wraps to 0", 128'(w[6:0]), 128'h0);
    push(0, 128'd999);
    chk("R9 overflow set", 128'(q_overflow[0]), 128'h1);
    rdcfg(0, w); chk("R9 ptrs unchanged", 128'(w[13:0]), 128'h0);
    for (int j = 0; j < 16; j++) pop(0, 128'(100 + j));
    flags(0, 1, 1, 0, 0, "R5 q0 drained");
    // R10 set wins over clear in the same cycle
    stat_clr = 1; stat_clr_qid = 0; stat_clr_mask = 2'b01;
    pop(0, 128'h0);
    stat_clr = 0;
    chk("R8 R10 underflow set wins", 128'(q_underflow[0]), 128'h1);
    rdcfg(0, w); chk("R8 rp unchanged", 128'(w[13:7]), 128'h0);
    stat_clr = 1; stat_clr_qid = 0; stat_clr_mask = 2'b01; @(negedge clk); stat_clr = 0;
    chk("R10 underflow cleared, overflow kept", 128'({q_underflow[0], q_overflow[0]}), 128'b01);
    stat_clr = 1; stat_clr_qid = 0; stat_clr_mask = 2'b10; @(negedge clk); stat_clr = 0;
    chk("R10 overflow cleared", 128'(q_overflow[0]), 128'h0);

    // queue 1: 4-word entries, 32 words (8 entries), base 1
    cfgw(1, mk(0, 0, 1, 2, 1, 0, 0));
    flags(1, 1, 1, 0, 0, "R6 q1 empty thr0");
    for (int j = 0; j < 8; j++) push(1, ent(1000 + 4 * j));
    flags(1, 0, 0, 1, 1, "R5 q1 full at 8");
    for (int j = 0; j < 3; j++) pop(1, ent(1000 + 4 * j));
    for (int j = 8; j < 11; j++) push(1, ent(1000 + 4 * j));
    flags(1, 0, 0, 1, 1, "R5 q1 full, equal ptrs");
    rdcfg(1, w); chk("R4 q1 ptrs 12/12", 128'({w[13:7], w[6:0]}), 128'({7'd12, 7'd12}));
    chk("R11 q0 untouched", 128'(q_empty[0]), 128'h1);
    for (int j = 3; j < 11; j++) pop(1, ent(1000 + 4 * j));
    flags(1, 1, 1, 0, 0, "R5 q1 drained");

    // queue 2: 2-word entries, 16 words, base 3, pointers seeded at 14
    cfgw(2, mk(14, 14, 3, 1, 0, 0, 0));
    flags(2, 1, 1, 0, 0, "R2 seeded ptrs empty");
    push(2, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0A02_0000_0A01});
    rdcfg(2, w); chk("R4 q2 wp wraps", 128'(w[6:0]), 128'h0);
    push(2, {64'h1234, 64'h0000_0B02_0000_0B01});
    pop(2, {64'h0, 64'h0000_0A02_0000_0A01});
    rdcfg(2, w); chk("R4 q2 rp wraps", 128'(w[13:7]), 128'h0);
    pop(2, {64'h0, 64'h0000_0B02_0000_0B01});

    // queue 3: access blocked by simultaneous control write
    cfg_we = 1; cfg_qid = 3; cfg_wdata = mk(0, 0, 4, 0, 0, 0, 0);
    acc_valid = 1; acc_write = 1; acc_qid = 3; acc_wdata = 128'h77;
    @(negedge clk); cfg_we = 0; acc_valid = 0;
    chk("R11 blocked push", 128'(q_empty[3]), 128'h1);
    rdcfg(3, w); chk("R11 cfg wins", 128'(w), 128'(mk(0, 0, 4, 0, 0, 0, 0)));
    push(3, 128'h55);
    pop(3, 128'h55);

    repeat (3) @(negedge clk);
    chk("R3 scoreboard empty", 128'(sbq.size()), 128'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule